// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides, once per system clock cycle, whether an 8-bit timer should advance. A 3-bit source code picks one of three kinds of source. The first is no source at all. The second is a free-running power-of-two divider of the system clock, at ratio 1, 8, 64, 256 or 1024. The third is an external input whose rising or falling transitions are counted. The result is a registered single-cycle enable pulse in the system clock domain. The timer counter consumes this pulse.

The divider is a 10-bit counter that starts at zero out of reset and never stops. Changing the source code does not disturb its phase. The external input passes through a two-stage synchronizer and then an edge detector. The detector has no direction qualifier, so transitions on the input count whether the pin is being driven from outside or from the chip itself.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst` is high, `tick_o` is 0 and the divider count is held at zero. Edges are numbered k = 1, 2, ... from the first rising clock edge with `rst` low. After edge k, the divider count equals k mod 1024.
- R2: With source code 000, `tick_o` stays 0, whatever the external input does.
- R3: With source code 001, `tick_o` is 1 after every clock edge.
- R4: With source code 010, `tick_o` is 1 after edge k exactly when k mod 8 = 0.
- R5: With source code 011, `tick_o` is 1 after edge k exactly when k mod 64 = 0.
- R6: With source code 100, `tick_o` is 1 after edge k exactly when k mod 256 = 0.
- R7: With source code 101, `tick_o` is 1 after edge k exactly when k mod 1024 = 0.
- R8: With source code 110, a 1-to-0 change of `ext_pin_i` first sampled at edge k makes `tick_o` 1 after edge k+2, for exactly one cycle.
- R9: With source code 111, a 0-to-1 change of `ext_pin_i` first sampled at edge k makes `tick_o` 1 after edge k+2, for exactly one cycle.
- R10: In either external mode, transitions of the opposite polarity produce no pulse. A level held for many cycles produces only one pulse.
- R11: The source code is applied at each edge. Switching codes never resets the divider, so the divided modes keep the phase given by R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel_i | input | 3 | Count source code (000 off, 001 /1, 010 /8, 011 /64, 100 /256, 101 /1024, 110 pin falling, 111 pin rising) |
| ext_pin_i | input | 1 | External count input, asynchronous |
| tick_o | output | 1 | Registered one-cycle count enable |

## Verification
Suppose the divider holds a wrong count, or steps wrongly. Then every divided mode emits its pulses at the wrong cycle numbers. At ratio 8 this shows up within 8 cycles. At ratio 1024 it can take up to 1024 cycles. A wrong synchronizer or edge-history value shows up as a pulse one cycle early or late, a missing pulse, or a pulse on the wrong polarity. This appears within three cycles of the input transition. The bench predicts the exact cycle of every expected pulse from the requirements, including pulses after a mode switch made long after reset. A phase slip or a latency error is therefore reported as a miscompare, not hidden.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [2:0] {
    CS_OFF      = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_PIN_FALL = 3'b110,
    CS_PIN_RISE = 3'b111
  } clk_src_e;

  localparam int unsigned N_TAPS = 4;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned LOG_A = 3,
  parameter int unsigned LOG_B = 6,
  parameter int unsigned LOG_C = 8,
  parameter int unsigned LOG_D = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [tick_pkg::N_TAPS-1:0] tap_o
);

  localparam int unsigned CNT_W = LOG_D;

  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] tap_mask(input int unsigned idx);
    int unsigned lg;
    case (idx)
      0:       lg = LOG_A;
      1:       lg = LOG_B;
      2:       lg = LOG_C;
      default: lg = LOG_D;
    endcase
    return {CNT_W{1'b1}} >> (CNT_W - lg);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // A tap is high in the cycle before its low bits wrap to zero.
  for (genvar j = 0; j < int'(tick_pkg::N_TAPS); j++) begin : g_tap
    localparam logic [CNT_W-1:0] MASK = tap_mask(j);
    assign tap_o[j] = ((cnt & MASK) == MASK);
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt[0] != $past(cnt[0]))); // R11
  AST_TAP_NEST_HI: assert property (@(posedge clk) disable iff (rst)
    tap_o[3] |-> tap_o[2]); // R7
  AST_TAP_NEST_MID: assert property (@(posedge clk) disable iff (rst)
    tap_o[2] |-> (tap_o[1] && tap_o[0])); // R6

endmodule

// File: rtl/tick_pin_edge.sv
module tick_pin_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  // sh[SYNC_STAGES-1] is the synchronized level; sh[SYNC_STAGES] is its history.
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], pin_i};
  end

  assign rise_o =  sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  assign fall_o = ~sh[SYNC_STAGES-1] &  sh[SYNC_STAGES];

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o)); // R10
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R10
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o); // R10

endmodule

// File: rtl/tick_src_mux.sv
module tick_src_mux
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  clk_src_e          sel_i,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              tick_o
);

  logic tick_d;

  always_comb begin
    case (sel_i)
      CS_OFF:      tick_d = 1'b0;
      CS_DIV1:     tick_d = 1'b1;
      CS_DIV8:     tick_d = tap_i[0];
      CS_DIV64:    tick_d = tap_i[1];
      CS_DIV256:   tick_d = tap_i[2];
      CS_DIV1024:  tick_d = tap_i[3];
      CS_PIN_FALL: tick_d = fall_i;
      CS_PIN_RISE: tick_d = rise_i;
      default:     tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= tick_d;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel_i == CS_OFF) |=> !tick_o); // R2
  AST_DIV1_FULL: assert property (@(posedge clk) disable iff (rst)
    (sel_i == CS_DIV1) |=> tick_o); // R3
  AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (sel_i == CS_PIN_RISE && fall_i) |=> !tick_o); // R9
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
    (sel_i == CS_PIN_FALL && rise_i) |=> !tick_o); // R8

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
  parameter int unsigned LOG_A       = 3,
  parameter int unsigned LOG_B       = 6,
  parameter int unsigned LOG_C       = 8,
  parameter int unsigned LOG_D       = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] clk_sel_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);

  import tick_pkg::*;

  logic [N_TAPS-1:0] taps;
  logic              pin_rise;
  logic              pin_fall;
  clk_src_e          sel;

  assign sel = clk_src_e'(clk_sel_i);

  tick_prescaler #(
    .LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C), .LOG_D(LOG_D)
  ) u_presc (
    .clk  (clk),
    .rst  (rst),
    .tap_o(taps)
  );

  tick_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst   (rst),
    .pin_i (ext_pin_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  tick_src_mux u_mux (
    .clk   (clk),
    .rst   (rst),
    .sel_i (sel),
    .tap_i (taps),
    .rise_i(pin_rise),
    .fall_i(pin_fall),
    .tick_o(tick_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !tick_o); // R1

endmodule

// File: tb/timer_tick_gen_tb.sv
module timer_tick_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'b001;
  logic       pin = 1'b0;
  logic       tick;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;
  string cur_tag = "R1";

  typedef struct { int at; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  timer_tick_gen u_dut (
    .clk(clk), .rst(rst), .clk_sel_i(sel), .ext_pin_i(pin), .tick_o(tick)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Monitor: compares each observed pulse with the scoreboard head.
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: tick missing at cycle %0d, actual 0 expected 1", q[0].tag, q[0].at);
        void'(q.pop_front());
      end
      if (tick) begin
        n_chk++;
        if (q.size() > 0 && q[0].at == cyc) begin
          void'(q.pop_front());
        end else begin
          n_fail++;
          $display("FAIL %s: unexpected tick at cycle %0d, actual 1 expected 0", cur_tag, cyc);
        end
      end
    end
  end

  task automatic push(int at, string tag);
    exp_t e;
    e.at = at; e.tag = tag;
    q.push_back(e);
  endtask

  // Driver for the off and divided modes (n = 0 means no pulses).
  task automatic run_div(logic [2:0] code, int n, int len, string tag);
    int c0;
    c0 = cyc;
    sel = code;
    cur_tag = tag;
    if (n > 0)
      for (int k = c0 + 1; k <= c0 + len; k++)
        if (k % n == 0) push(k, tag);
    repeat (len) @(negedge clk);
  endtask

  // Driver for the pin modes; a change made now is sampled at the next edge.
  task automatic run_pin(logic [2:0] code, bit rising, string tag);
    int holds [6] = '{1, 1, 3, 5, 2, 7};
    sel = code;
    cur_tag = tag;
    for (int i = 0; i < 6; i++) begin
      pin = ~pin;
      if ((code != 3'b000) && (pin == rising)) push(cyc + 3, tag);
      repeat (holds[i]) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    n_chk++;
    if (tick !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: tick during reset, actual %b expected 0", tick);
    end
    rst = 1'b0;
    run_div(3'b010, 8, 40, "R1");     // R1, R4: phase counted from reset
    run_div(3'b001, 1, 20, "R3");
    run_div(3'b000, 0, 30, "R2");
    run_pin(3'b000, 1'b1, "R2");      // R2: pin activity while off
    run_div(3'b011, 64, 200, "R5");
    run_div(3'b100, 256, 600, "R6");
    run_div(3'b101, 1024, 2200, "R7");
    run_div(3'b010, 8, 30, "R11");    // R11: phase survives mode switches
    run_pin(3'b111, 1'b1, "R9");
    run_pin(3'b110, 1'b0, "R8");
    run_pin(3'b111, 1'b1, "R10");     // R10: opposite edges ignored
    run_pin(3'b110, 1'b0, "R10");
    run_div(3'b100, 256, 300, "R11");
    sel = 3'b000;
    cur_tag = "R2";
    repeat (5) @(negedge clk);
    while (q.size() > 0) begin
      n_chk++; n_fail++;
      $display("FAIL %s: tick never seen at %0d, actual 0 expected 1", q[0].tag, q[0].at);
      void'(q.pop_front());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule